// File: doc/BRIEF.md
# Shift-Aware Hybrid Approximate Adder

This adder sits in the add trees of constant-coefficient filters. In those trees each operand is a product term left-shifted by a known constant. Both operands arrive already shifted. Operand `a_i` carries the smaller shift, `K1` bits, and operand `b_i` carries the larger shift, `K1+K2` bits. The adder uses these known zero bits to save logic. It splits the result into four bit regions, starting from the LSB:

- a truncated region of `K1` bits, where both operands are zero;
- a pass-through region of `K2` bits, where only `a_i` can be nonzero, so its bits are copied;
- an approximate region of `K3` bits;
- an exact ripple region for all remaining upper bits.

The approximate region works in one of two styles, chosen at compile time. In copy style, the region takes the bits of `a_i` directly. In error-tolerant style, the region scans downward from its top bit and saturates to ones below the first position where both operand bits are one. The exact region does not wait for a real carry out of the lower bits. Instead it takes a predicted carry, which is the `b_i` bit at the top of the approximate region. The sum is registered once, so the result of the inputs sampled at one clock edge appears right after that edge.

Top module: `shift_approx_adder`

## Requirements
- R1: While `rst_ni` is low, `sum_o` and `cout_o` are 0.
- R2: Latency is one cycle. The output after a rising edge reflects the inputs sampled at that edge.
- R3: Sum bits `[K1-1:0]` are always 0, whatever the inputs hold in those bits.
- R4: Sum bits `[K1+K2-1:K1]` equal the same bits of `a_i`. The bits of `b_i` in this range have no effect.
- R5: In copy style (`MODE=APX_COPY`), sum bits `[K1+K2+K3-1:K1+K2]` equal the same bits of `a_i`.
- R6: In error-tolerant style (`MODE=APX_ETOL`), the approximate region is scanned from its top bit down. At the highest position where `a_i` and `b_i` are both 1, that sum bit and every lower bit of the region are 1.
- R7: In error-tolerant style, any region bit above that position, or every region bit when no such position exists, is `a_i | b_i`.
- R8: The upper bits `{cout_o, sum_o[N-1:K1+K2+K3]}` equal the sum of the upper bits of `a_i`, the upper bits of `b_i`, and a carry-in. That carry-in is `b_i[K1+K2+K3-1]` when `K3>0` and 0 otherwise.
- R9: With `K1=K2=K3=0`, `{cout_o, sum_o}` equals `a_i + b_i` exactly.
- R10: For operands that honour the shifts (`a_i` low `K1` bits zero, `b_i` low `K1+K2` bits zero), the output matches the region rules above for every operand pair in both styles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | N | Operand with the smaller shift (`K1`) |
| b_i | input | N | Operand with the larger shift (`K1+K2`) |
| sum_o | output | N | Registered approximate sum |
| cout_o | output | 1 | Registered carry out of the exact region |

## Verification
The bench builds three instances that share one clock and reset:

- two 16-bit adders with `K1=2`, `K2=2`, `K3=4`, one in copy style and one in error-tolerant style;
- a 12-bit adder with every region width set to zero.

The two 16-bit instances receive the same operands, so a single stimulus shows the two approximation styles side by side. That stimulus covers predicted carries that either fix or create an error, overflow of the exact part, and no-generate cases in the scan. Driving nonzero bits into the shifted-out positions shows that the truncated and copied regions ignore them. The zero-width instance covers the degenerate case in which the same structure reduces to an exact adder.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {
    APX_COPY = 1'b0,
    APX_ETOL = 1'b1
  } apx_mode_e;
endpackage

// File: rtl/sa_low_region.sv
module sa_low_region #(
  parameter int K1 = 2,
  parameter int K2 = 2,
  localparam int L = K1 + K2
) (
  input  logic [L-1:0] a_i,
  input  logic [L-1:0] b_i,
  output logic [L-1:0] sum_o
);
  // b is zero across the whole low region by shift; a is zero below K1
  logic unused_lo;
  assign unused_lo = ^{a_i, b_i};

  for (genvar i = 0; i < L; i++) begin : g_bit
    if (i < K1) begin : g_trunc
      assign sum_o[i] = 1'b0;
    end else begin : g_copy
      assign sum_o[i] = a_i[i];
    end
  end
endmodule

// File: rtl/sa_approx_region.sv
module sa_approx_region
  import sa_pkg::*;
#(
  parameter int        W    = 4,
  parameter apx_mode_e MODE = APX_COPY
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  if (MODE == APX_COPY) begin : g_copy
    logic unused_b;
    assign unused_b = ^b_i;
    assign sum_o    = a_i;
  end else begin : g_etol
    // hit[i]: some position at or above i has both bits set
    logic [W:0] hit;
    assign hit[W] = 1'b0;
    for (genvar i = W - 1; i >= 0; i--) begin : g_scan
      assign hit[i]   = hit[i+1] | (a_i[i] & b_i[i]);
      assign sum_o[i] = hit[i] | a_i[i] | b_i[i];
    end
  end
endmodule

// File: rtl/sa_exact_region.sv
module sa_exact_region #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end
  assign cout_o = c[W];
endmodule

// File: rtl/shift_approx_adder.sv
module shift_approx_adder
  import sa_pkg::*;
#(
  parameter int        N    = 16,
  parameter int        K1   = 2,
  parameter int        K2   = 2,
  parameter int        K3   = 4,
  parameter apx_mode_e MODE = APX_COPY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  localparam int L = K1 + K2;
  localparam int H = L + K3;
  localparam int W = N - H;

  logic [N-1:0] sum_c;
  logic         cout_c;
  logic         cin_est;

  if (L > 0) begin : g_low
    sa_low_region #(.K1(K1), .K2(K2)) u_low (
      .a_i  (a_i[L-1:0]),
      .b_i  (b_i[L-1:0]),
      .sum_o(sum_c[L-1:0])
    );
  end

  if (K3 > 0) begin : g_apx
    sa_approx_region #(.W(K3), .MODE(MODE)) u_apx (
      .a_i  (a_i[H-1:L]),
      .b_i  (b_i[H-1:L]),
      .sum_o(sum_c[H-1:L])
    );
    assign cin_est = b_i[H-1];
  end else begin : g_no_apx
    assign cin_est = 1'b0;
  end

  sa_exact_region #(.W(W)) u_exact (
    .a_i   (a_i[N-1:H]),
    .b_i   (b_i[N-1:H]),
    .cin_i (cin_est),
    .sum_o (sum_c[N-1:H]),
    .cout_o(cout_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= cout_c;
    end
  end
endmodule

// File: rtl/shift_approx_adder_chk.sv
module shift_approx_adder_chk
  import sa_pkg::*;
#(
  parameter int        N    = 16,
  parameter int        K1   = 2,
  parameter int        K2   = 2,
  parameter int        K3   = 4,
  parameter apx_mode_e MODE = APX_COPY
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N-1:0] sum_o,
  input logic         cout_o
);
  localparam int L = K1 + K2;
  localparam int H = L + K3;
  localparam int W = N - H;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (sum_o == '0 && cout_o == 1'b0); // R1
    end
  end

  if (K1 > 0) begin : g_trunc
    AST_TRUNC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> sum_o[K1-1:0] == '0); // R3
  end

  if (K2 > 0) begin : g_pass
    AST_PASS_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> sum_o[L-1:K1] == $past(a_i[L-1:K1])); // R4
  end

  if (K3 > 0) begin : g_apx
    if (MODE == APX_COPY) begin : g_copy
      AST_APX_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> sum_o[H-1:L] == $past(a_i[H-1:L])); // R5
    end else begin : g_etol
      AST_ETOL_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && $past(a_i[H-1] & b_i[H-1]) |-> sum_o[H-1:L] == '1); // R6
      AST_ETOL_TOP_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> sum_o[H-1] == $past(a_i[H-1] | b_i[H-1])); // R7
    end
    AST_EXACT_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> {cout_o, sum_o[N-1:H]} ==
        ({1'b0, $past(a_i[N-1:H])} + {1'b0, $past(b_i[N-1:H])}
         + (W+1)'($past(b_i[H-1])))); // R8
  end else begin : g_noapx
    AST_EXACT_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> {cout_o, sum_o[N-1:H]} ==
        ({1'b0, $past(a_i[N-1:H])} + {1'b0, $past(b_i[N-1:H])})); // R8
  end
endmodule

bind shift_approx_adder shift_approx_adder_chk #(
  .N(N), .K1(K1), .K2(K2), .K3(K3), .MODE(MODE)
) u_chk (.*);

// File: tb/sim_shift_approx_adder.sv
module sim_shift_approx_adder;
  import sa_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [11:0] ea = '0, eb = '0;
  logic [15:0] s_cp, s_et;
  logic        c_cp, c_et;
  logic [11:0] s_ex;
  logic        c_ex;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  shift_approx_adder #(.N(16), .K1(2), .K2(2), .K3(4), .MODE(APX_COPY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sum_o(s_cp), .cout_o(c_cp));
  shift_approx_adder #(.N(16), .K1(2), .K2(2), .K3(4), .MODE(APX_ETOL)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .sum_o(s_et), .cout_o(c_et));
  shift_approx_adder #(.N(12), .K1(0), .K2(0), .K3(0), .MODE(APX_COPY)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(ea), .b_i(eb), .sum_o(s_ex), .cout_o(c_ex));

  // region rules for N=16, K1=2, K2=2, K3=4
  function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input bit etol);
    logic [15:0] s;
    logic [8:0]  up;
    bit          hit;
    s   = '0;
    hit = 1'b0;
    for (int i = 2; i < 4; i++) s[i] = x[i];
    for (int i = 7; i >= 4; i--) begin
      if (!etol) s[i] = x[i];
      else begin
        if (x[i] && y[i]) hit = 1'b1;
        s[i] = hit ? 1'b1 : (x[i] | y[i]);
      end
    end
    up = {1'b0, x[15:8]} + {1'b0, y[15:8]} + 9'(y[7]);
    s[15:8] = up[7:0];
    return {up[8], s};
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 copy", {c_cp, s_cp}, 17'h0);
    chk("R1 etol", {c_et, s_et}, 17'h0);
    chk("R1 exact", {4'h0, c_ex, s_ex}, 17'h0);
  endtask

  task automatic t_directed();
    drive(16'h0054, 16'h0060);
    chk("R5 copy region", {c_cp, s_cp}, 17'h00054);
    chk("R6 saturate below gen", {c_et, s_et}, 17'h00074);
    drive(16'h0080, 16'h0080);
    chk("R8 predicted carry", {c_cp, s_cp}, 17'h00180);
    chk("R6 gen at top", {c_et, s_et}, 17'h001F0);
    drive(16'hFF00, 16'hFF80);
    chk("R8 carry out copy", {c_cp, s_cp}, 17'h1FF00);
    chk("R7 no gen OR", {c_et, s_et}, 17'h1FF80);
    // R2: second input takes effect exactly one edge later
    @(negedge clk); a = 16'h1230; b = 16'h0000;
    @(negedge clk); a = 16'h0004; b = 16'h0010;
    chk("R2 latency first", {c_cp, s_cp}, 17'h01230);
    @(negedge clk);
    chk("R2 latency second", {c_cp, s_cp}, 17'h00004);
  endtask

  task automatic t_ignored();
    // shifted-out bits driven nonzero: truncation ignores a/b, pass region ignores b
    drive(16'h0007, 16'h000F);
    chk("R3 trunc zero", {13'h0, s_cp[3:0]}, 17'h4);
    chk("R4 pass copies a", {13'h0, s_et[3:0]}, 17'h4);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      logic [15:0] x, y;
      x = 16'($urandom) & 16'hFFFC;
      y = 16'($urandom) & 16'hFFF0;
      drive(x, y);
      chk("R10 copy random", {c_cp, s_cp}, model(x, y, 1'b0));
      chk("R10 etol random", {c_et, s_et}, model(x, y, 1'b1));
    end
  endtask

  task automatic t_exact();
    logic [11:0] xs[4] = '{12'hFFF, 12'h800, 12'h000, 12'hAAA};
    logic [11:0] ys[4] = '{12'h001, 12'h800, 12'h000, 12'h555};
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); ea = xs[n]; eb = ys[n];
      @(negedge clk);
      chk("R9 exact corner", {4'h0, c_ex, s_ex}, {4'h0, {1'b0, xs[n]} + {1'b0, ys[n]}});
    end
    for (int n = 0; n < 200; n++) begin
      logic [11:0] x, y;
      x = 12'($urandom);
      y = 12'($urandom);
      @(negedge clk); ea = x; eb = y;
      @(negedge clk);
      chk("R9 exact random", {4'h0, c_ex, s_ex}, {4'h0, {1'b0, x} + {1'b0, y}});
    end
  endtask

  initial begin
    a = 16'hFFFF;
    b = 16'hFFFF;
    ea = 12'hFFF;
    eb = 12'hFFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_directed();
    t_ignored();
    t_random();
    t_exact();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule